// File: doc/BRIEF.md
# Masked Eight-Column Block-Write Engine

This block is the write path and storage array of a small synchronous multiport memory. The array holds 16-bit words arranged as rows of columns. A controller drives it through active-low byte strobes for the two lanes, an active-low write strobe, a mode-select input and a shared 16-bit bus. Each strobe cycle performs exactly one write. That write is either an ordinary single-word write, or a block write that copies a stored color word into up to eight aligned columns at once.

In a block write, the bus word is not data. It is taken as two 8-column masks, one per byte lane. A separate per-bit write mask then limits which bit positions may change. Both the color word and the write mask are loaded through a register-load command. A combinational read port returns any word, so results can be inspected.

Top module: `blkwr_core`

## Requirements
- R1: After reset every array word is 0x0000, the color register is 0x0000 and the write mask is 0xFFFF, so a block write issued before any mask load changes every bit lane it selects.
- R2: With `reg_load` high on a clock edge, the bus word is stored into the color register when `reg_sel` is 0 and into the write mask when `reg_sel` is 1.
- R3: The cycle type, the row and the column are taken at the first falling edge of either column strobe. `mode_sel` high there selects a block write and low selects a word write. Later changes to these inputs within the same strobe cycle are ignored.
- R4: Falling `cas_lo_n` enables bits 7:0 and falling `cas_hi_n` enables bits 15:8. A lane whose strobe is not asserted keeps its previous contents.
- R5: The bus is captured at whichever comes later: the write-strobe fall or the first column-strobe fall. This covers both the early-write and the late-write order. Bus values before that point do not reach the array.
- R6: A word write stores the captured bus word into the addressed word on the enabled lanes. The write mask does not apply to it.
- R7: In a block write, column-address bits 2:0 are ignored. The upper column bits select the eight columns group*8 to group*8+7, and no column outside that group changes.
- R8: In a block write, captured bus bit c enables bits 7:0 of group column c, and bus bit 8+c enables bits 15:8 of group column c.
- R9: In a block write, every enabled bit takes the color-register bit at the same position. A bit whose write-mask bit is 0 keeps its previous value in every column.
- R10: Each strobe cycle writes at most once, so bus changes after the capture point do not rewrite. A write made visible by an input edge appears on `rd_data` after the third rising clock edge that follows that edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_lo_n | input | 1 | Active-low column strobe, lower byte lane |
| cas_hi_n | input | 1 | Active-low column strobe, upper byte lane |
| we_n | input | 1 | Active-low write strobe |
| mode_sel | input | 1 | Block-write select, sampled at first column-strobe fall |
| row_addr | input | ROW_BITS | Row address, sampled at first column-strobe fall |
| col_addr | input | COL_BITS | Column address, sampled at first column-strobe fall |
| dq_in | input | 16 | Shared bus: write data, column masks or register load value |
| reg_load | input | 1 | Load a register from `dq_in` on this clock |
| reg_sel | input | 1 | Register-load target: 0 color, 1 write mask |
| rd_row | input | ROW_BITS | Read-port row |
| rd_col | input | COL_BITS | Read-port column |
| rd_data | output | 16 | Word stored at `rd_row`/`rd_col` |

## Verification
The bench drives the mode select and the column address to the opposite value after the first strobe fall. A design that samples them late would then perform the wrong kind of write, or write to the wrong place. The bench also puts a decoy value on the bus before the capture point and another after it. Capturing at the earlier strobe, or writing more than once per cycle, would therefore leave the decoy in the array. A block write with an uneven mask pattern and a sparse write mask shows swapped lane-to-column mapping and ignored mask bits as wrong columns or bits. Single-lane cycles and a block write in a high group expose lane leakage and failure to drop the low column bits. A cycle-exact latency probe catches an extra or missing pipeline stage.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;
    localparam int WORD_W      = 16;
    localparam int LANE_W      = 8;
    localparam int LANES       = WORD_W / LANE_W;
    localparam int GROUP_SHIFT = 3;
    localparam int GROUP_COLS  = 1 << GROUP_SHIFT;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_t;

    typedef enum logic {OP_WORD = 1'b0, OP_BLOCK = 1'b1} op_e;
    typedef enum logic {SEL_COLOR = 1'b0, SEL_WMASK = 1'b1} regsel_e;

    typedef struct packed {
        op_e   op;
        lane_t ben;
        word_t bus;
    } wr_cmd_t;

    function automatic word_t lane_expand(lane_t l);
        word_t r;
        for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = {LANE_W{l[i]}};
        return r;
    endfunction

    function automatic word_t colmask_lanes(word_t cm, int unsigned c);
        word_t r;
        for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = {LANE_W{cm[i*GROUP_COLS + c]}};
        return r;
    endfunction

    function automatic word_t bit_merge(word_t old_w, word_t new_w, word_t en);
        return (old_w & ~en) | (new_w & en);
    endfunction
endpackage

// File: rtl/blkwr_edge_sync.sv
module blkwr_edge_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] low,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_sync
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
                s3 <= 1'b1;
            end else begin
                s1 <= raw_n[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign low[i]  = ~s2;
        assign fall[i] = s3 & ~s2;
    end
endmodule

// File: rtl/blkwr_cycle_ctl.sv
module blkwr_cycle_ctl
    import blkwr_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  lane_t               cas_low,
    input  lane_t               cas_fall,
    input  logic                we_low,
    input  logic                mode_sel,
    input  logic [ROW_BITS-1:0] row_in,
    input  logic [COL_BITS-1:0] col_in,
    input  word_t               bus_in,
    output logic                commit,
    output wr_cmd_t             cmd,
    output logic [ROW_BITS-1:0] row_out,
    output logic [COL_BITS-1:0] col_out
);
    logic                open_q, done_q;
    op_e                 op_q;
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    logic                first, closing, cas_ok;

    assign first   = !open_q && (|cas_fall);
    assign closing = open_q && !(|cas_low);
    assign cas_ok  = open_q || first;
    assign commit  = cas_ok && (|cas_low) && we_low && !done_q;

    assign cmd.op  = first ? op_e'(mode_sel) : op_q;
    assign cmd.ben = cas_low;
    assign cmd.bus = bus_in;
    assign row_out = first ? row_in : row_q;
    assign col_out = first ? col_in : col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            done_q <= 1'b0;
            op_q   <= OP_WORD;
            row_q  <= '0;
            col_q  <= '0;
        end else if (first) begin
            open_q <= 1'b1;
            done_q <= commit;
            op_q   <= op_e'(mode_sel);
            row_q  <= row_in;
            col_q  <= col_in;
        end else if (closing) begin
            open_q <= 1'b0;
            done_q <= 1'b0;
        end else if (commit) begin
            done_q <= 1'b1;
        end
    end

    // R10: no second write in the same strobe cycle
    p_single_commit_r10: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R3: cycle type frozen while a strobe cycle stays open
    p_op_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (open_q && $past(open_q)) |-> $stable(op_q));
endmodule

// File: rtl/blkwr_array.sv
module blkwr_array
    import blkwr_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  wr_cmd_t             cmd,
    input  logic [ROW_BITS-1:0] row,
    input  logic [COL_BITS-1:0] col,
    input  word_t               color,
    input  word_t               wmask,
    input  logic [ROW_BITS-1:0] rd_row,
    input  logic [COL_BITS-1:0] rd_col,
    output word_t               rd_data
);
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int COLS     = 1 << COL_BITS;
    localparam int GRP_BITS = COL_BITS - GROUP_SHIFT;

    word_t               mem [ROWS][COLS];
    word_t               lane_en;
    word_t               blk_en [GROUP_COLS];
    logic [GRP_BITS-1:0] grp;

    assign lane_en = lane_expand(cmd.ben);
    assign grp     = col[COL_BITS-1:GROUP_SHIFT];

    for (genvar g = 0; g < GROUP_COLS; g++) begin : g_col_en
        assign blk_en[g] = lane_en & wmask & colmask_lanes(cmd.bus, g);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    mem[r][c] <= '0;
        end else if (commit) begin
            if (cmd.op == OP_BLOCK) begin
                for (int g = 0; g < GROUP_COLS; g++)
                    mem[row][{grp, GROUP_SHIFT'(g)}] <=
                        bit_merge(mem[row][{grp, GROUP_SHIFT'(g)}], color, blk_en[g]);
            end else begin
                mem[row][col] <= bit_merge(mem[row][col], cmd.bus, lane_en);
            end
        end
    end

    assign rd_data = mem[rd_row][rd_col];

    // R6: full-width word write lands exactly
    p_word_write_r6: assert property (@(posedge clk) disable iff (rst)
        (commit && cmd.op == OP_WORD && cmd.ben == 2'b11)
        |=> mem[$past(row)][$past(col)] == $past(cmd.bus));

    // R4: upper lane of the addressed word holds when its strobe is idle
    p_idle_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (commit && !cmd.ben[1])
        |=> mem[$past(row)][$past(col)][15:8] == $past(mem[row][col][15:8]));
endmodule

// File: rtl/blkwr_core.sv
module blkwr_core
    import blkwr_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cas_lo_n,
    input  logic                cas_hi_n,
    input  logic                we_n,
    input  logic                mode_sel,
    input  logic [ROW_BITS-1:0] row_addr,
    input  logic [COL_BITS-1:0] col_addr,
    input  logic [15:0]         dq_in,
    input  logic                reg_load,
    input  logic                reg_sel,
    input  logic [ROW_BITS-1:0] rd_row,
    input  logic [COL_BITS-1:0] rd_col,
    output logic [15:0]         rd_data
);
    logic [2:0]          s_low, s_fall;
    logic                unused_we_fall;
    logic                commit;
    wr_cmd_t             cmd;
    logic [ROW_BITS-1:0] w_row;
    logic [COL_BITS-1:0] w_col;
    word_t               color_q, wmask_q;

    assign unused_we_fall = s_fall[2];

    blkwr_edge_sync #(.N(3)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_n ({we_n, cas_hi_n, cas_lo_n}),
        .low   (s_low),
        .fall  (s_fall)
    );

    blkwr_cycle_ctl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .cas_low  (s_low[1:0]),
        .cas_fall (s_fall[1:0]),
        .we_low   (s_low[2]),
        .mode_sel (mode_sel),
        .row_in   (row_addr),
        .col_in   (col_addr),
        .bus_in   (dq_in),
        .commit   (commit),
        .cmd      (cmd),
        .row_out  (w_row),
        .col_out  (w_col)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            color_q <= '0;
            wmask_q <= '1;
        end else if (reg_load) begin
            if (regsel_e'(reg_sel) == SEL_WMASK) wmask_q <= dq_in;
            else                                 color_q <= dq_in;
        end
    end

    blkwr_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_array (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .cmd     (cmd),
        .row     (w_row),
        .col     (w_col),
        .color   (color_q),
        .wmask   (wmask_q),
        .rd_row  (rd_row),
        .rd_col  (rd_col),
        .rd_data (rd_data)
    );

    // R1: write mask comes out of reset as all ones
    p_wmask_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> wmask_q == 16'hFFFF);
endmodule

// File: tb/blkwr_core_tb.sv
module blkwr_core_tb;
    localparam int RB = 2;
    localparam int CB = 5;
    localparam int NR = 1 << RB;
    localparam int NC = 1 << CB;

    logic          clk = 1'b0;
    logic          rst;
    logic          cas_lo_n, cas_hi_n, we_n, mode_sel;
    logic [RB-1:0] row_addr, rd_row;
    logic [CB-1:0] col_addr, rd_col;
    logic [15:0]   dq_in, rd_data;
    logic          reg_load, reg_sel;

    always #5 clk = ~clk;

    blkwr_core #(.ROW_BITS(RB), .COL_BITS(CB)) u_dut (
        .clk(clk), .rst(rst), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n),
        .we_n(we_n), .mode_sel(mode_sel), .row_addr(row_addr), .col_addr(col_addr),
        .dq_in(dq_in), .reg_load(reg_load), .reg_sel(reg_sel),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    logic [15:0] model [NR*NC];
    logic [15:0] m_color, m_wmask;
    int checks = 0;
    int fails  = 0;

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_chk(string tag, int r, int c, logic [15:0] exp);
        @(negedge clk);
        rd_row = RB'(r);
        rd_col = CB'(c);
        #1 chk(tag, rd_data, exp);
    endtask

    task automatic sweep(string tag);
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                read_chk(tag, r, c, model[r*NC + c]);
    endtask

    task automatic model_apply(bit blk, int r, int c, bit lo, bit hi, logic [15:0] bus);
        logic [15:0] lanes, en;
        int base, idx;
        lanes = {{8{hi}}, {8{lo}}};
        if (blk) begin
            base = c & ~7;
            for (int k = 0; k < 8; k++) begin
                en  = lanes & m_wmask & {{8{bus[8+k]}}, {8{bus[k]}}};
                idx = r*NC + base + k;
                model[idx] = (model[idx] & ~en) | (m_color & en);
            end
        end else begin
            idx = r*NC + c;
            model[idx] = (model[idx] & ~lanes) | (bus & lanes);
        end
    endtask

    task automatic load(bit sel, logic [15:0] val);
        @(negedge clk);
        reg_load = 1'b1;
        reg_sel  = sel;
        dq_in    = val;
        @(negedge clk);
        reg_load = 1'b0;
        if (sel) m_wmask = val; else m_color = val;
    endtask

    task automatic release_all();
        @(negedge clk);
        cas_lo_n = 1'b1;
        cas_hi_n = 1'b1;
        we_n     = 1'b1;
        wait_n(4);
    endtask

    // decoy bus values before and after capture, mode and column flipped after first strobe
    task automatic run_cycle(bit blk, int r, int c, bit lo, bit hi, bit early,
                             logic [15:0] bus, logic [15:0] junk);
        @(negedge clk);
        if (early) begin
            dq_in = bus;
            we_n  = 1'b0;
            wait_n(4);
            row_addr = RB'(r); col_addr = CB'(c); mode_sel = blk;
            cas_lo_n = !lo; cas_hi_n = !hi;
            wait_n(4);
            mode_sel = !blk; col_addr = CB'(c ^ 8); dq_in = junk;
        end else begin
            row_addr = RB'(r); col_addr = CB'(c); mode_sel = blk; dq_in = junk;
            cas_lo_n = !lo; cas_hi_n = !hi;
            wait_n(4);
            mode_sel = !blk; col_addr = CB'(c ^ 8); dq_in = bus;
            we_n = 1'b0;
            wait_n(4);
            dq_in = junk;
        end
        wait_n(3);
        release_all();
        model_apply(blk, r, c, lo, hi, bus);
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cas_lo_n = 1'b1; cas_hi_n = 1'b1; we_n = 1'b1; mode_sel = 1'b0;
        row_addr = '0; col_addr = '0; dq_in = '0; reg_load = 1'b0; reg_sel = 1'b0;
        rd_row = '0; rd_col = '0;
        for (int i = 0; i < NR*NC; i++) model[i] = '0;
        m_color = '0;
        m_wmask = 16'hFFFF;
        wait_n(4);
        @(negedge clk) rst = 1'b0;

        sweep("R1 reset array");

        // R1 + R2 + R7 + R8: block write with mask from reset, group 1
        load(1'b0, 16'hA5C3);
        run_cycle(1'b1, 0, 5'b01010, 1'b1, 1'b1, 1'b0, 16'hF00F, 16'h0FF0);
        read_chk("R1 reset wmask all ones", 0, 8, 16'h00C3);
        read_chk("R8 upper mask column 4", 0, 12, 16'hA500);
        read_chk("R7 column below group", 0, 7, 16'h0000);
        read_chk("R7 column above group", 0, 16, 16'h0000);

        // R5 + R6: early word write, then late lower-only word write
        run_cycle(1'b0, 2, 7, 1'b1, 1'b1, 1'b1, 16'h1234, 16'hEEEE);
        read_chk("R5 early capture", 2, 7, 16'h1234);
        run_cycle(1'b0, 2, 7, 1'b1, 1'b0, 1'b0, 16'hABCD, 16'h5555);
        read_chk("R4 lower lane only", 2, 7, 16'h12CD);

        // R2 + R8 + R9: sparse write mask, uneven column masks, group 0
        load(1'b1, 16'hDF0F);
        load(1'b0, 16'hDDF7);
        run_cycle(1'b1, 1, 5'b00110, 1'b1, 1'b1, 1'b0, 16'h5E0F, 16'hA1A1);
        read_chk("R9 col0", 1, 0, 16'h0007);
        read_chk("R9 col1", 1, 1, 16'hDD07);
        read_chk("R8 col3", 1, 3, 16'hDD07);
        read_chk("R8 col4", 1, 4, 16'hDD00);
        read_chk("R8 col5 untouched", 1, 5, 16'h0000);
        read_chk("R9 col6", 1, 6, 16'hDD00);
        read_chk("R8 col7 untouched", 1, 7, 16'h0000);

        // R6: word write ignores write mask; R3: mode high after fall ignored
        run_cycle(1'b0, 1, 0, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0000);
        read_chk("R6 unmasked word", 1, 0, 16'hFFFF);
        read_chk("R3 no block spill", 1, 1, 16'hDD07);

        // R4 + R7: upper lane only, group 2
        run_cycle(1'b1, 3, 5'b10011, 1'b0, 1'b1, 1'b1, 16'hFFFF, 16'h0000);
        read_chk("R7 group 2 base", 3, 16, 16'hDD00);
        read_chk("R4 upper only", 3, 19, 16'hDD00);
        read_chk("R7 after group 2", 3, 24, 16'h0000);

        // R10: cycle-exact latency of a late word write
        @(negedge clk);
        row_addr = 2'd3; col_addr = 5'd31; mode_sel = 1'b0; dq_in = 16'h0000;
        cas_lo_n = 1'b0; cas_hi_n = 1'b0;
        wait_n(4);
        rd_row = 2'd3; rd_col = 5'd31;
        dq_in = 16'h5A5A; we_n = 1'b0;
        @(posedge clk); @(posedge clk);
        #1 chk("R10 not yet after second edge", rd_data, 16'h0000);
        @(posedge clk);
        #1 chk("R10 visible after third edge", rd_data, 16'h5A5A);
        @(negedge clk) dq_in = 16'h1111;
        wait_n(4);
        #1 chk("R10 single write per cycle", rd_data, 16'h5A5A);
        release_all();
        model_apply(1'b0, 3, 31, 1'b1, 1'b1, 16'h5A5A);

        sweep("R3 R7 full compare");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule